// File: doc/BRIEF.md
# Dual GPIO Port with Analog-Shared Pins and Privilege Checking

This block gives software register access to two 8-bit digital ports whose pins double as analog inputs. Port A is bidirectional, with a per-bit direction register and an output latch. Port B can only be read. Input levels reach the bus through a two-stage synchronizer. That synchronizer is clocked only while a bus cycle targets a port data register, so at other times the digital input stage does not follow mid-level analog voltages.

Setting a mode bit routes an external multiplexer address to the three low pins of port A. In that mode those pins become outputs whatever the direction bits say, and reads of them return the latched address. Each register access passes a privilege check first. The two global registers always require supervisor privilege. The remaining registers require it only while a protection bit in the configuration register is set. An access that is refused ends with a transfer-error response and changes nothing.

The bus is a request/hold interface. The master raises `bus_req` with a stable address, direction and write data, and it keeps them until it sees `bus_ack` or `bus_terr` for one cycle. It drops `bus_req` in that same cycle.

Top module: `gpio_shared_port`

## Requirements
- R1: After reset, all port A pins are inputs (`pa_oe` = 0) and `pa_out` = 0. The config register (address 0x0, bit 0 = protect) reads 0x01. The direction register (0x4) reads 0x00. The control register (0x5, bit 0 = mux mode) reads 0x00. The IRQ register (0x1) reads 0x00.
- R2: With mux mode off, `pa_oe[i]` equals direction bit i (1 = output), and `pa_out` equals the port A latch that was written at address 0x2.
- R3: A read of port A (0x2) returns the output latch for output bits and the synchronized pin level for input bits.
- R4: A read of port B (0x3) returns the synchronized `pb_in` levels. A write to 0x3 is acknowledged without error and has no effect on later reads.
- R5: A permitted read of a port data register is acknowledged two cycles after the request is first sampled. Every other permitted access is acknowledged one cycle after.
- R6: The input synchronizers change only in cycles that access a port data register. In all other cycles they hold their value.
- R7: With mux mode on, `pa_oe[2:0]` are all 1 and `pa_out[2:0]` carry `mux_addr`, registered once, regardless of direction bits.
- R8: With mux mode on, port A read bits [2:0] return the registered multiplexer address.
- R9: Direction bits written while mux mode overrides them are stored and read back as written. They take effect on the pins once mux mode is cleared.
- R10: A user-level access (`bus_supv` = 0) to 0x0 or 0x1 gets `bus_terr` and leaves the registers unchanged.
- R11: Addresses 0x2 to 0xF reject user-level access with `bus_terr` while protect = 1, and accept it while protect = 0. Unmapped addresses read 0.
- R12: Each request gets exactly one response cycle, and `bus_ack` and `bus_terr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, held until response |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_supv | input | 1 | Requester runs at supervisor privilege |
| bus_rdata | output | 8 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | Access completed |
| bus_terr | output | 1 | Access refused (privilege) |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output drive values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| mux_addr | input | 3 | External multiplexer address to drive in mux mode |

## Verification
The hardest state to reach combines mux mode with a conflicting direction register and a protection setting that changes between accesses, and then follows it with a read while pins and the multiplexer address differ. Random operation sequences with random privilege levels toggle the protect and mux bits. Each random step also changes the pin and address inputs, and a bench model tracks which bits must come from latch, pin or address. Directed sequences then write direction bits under mux mode and clear it, so that the stored values show up on the pins.

// File: rtl/gpio_shared_pkg.sv
// Shared constants and types for the dual GPIO port block.
// Assumes a 4-bit register address space with six mapped registers.
package gpio_shared_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CFG  = 4'h0;
    localparam logic [ADDR_W-1:0] A_IRQ  = 4'h1;
    localparam logic [ADDR_W-1:0] A_PA   = 4'h2;
    localparam logic [ADDR_W-1:0] A_PB   = 4'h3;
    localparam logic [ADDR_W-1:0] A_DIR  = 4'h4;
    localparam logic [ADDR_W-1:0] A_CTRL = 4'h5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } bus_st_e;

    typedef enum logic [1:0] {
        RD_HOLD = 2'd0,
        RD_PA   = 2'd1,
        RD_PB   = 2'd2
    } rd_src_e;
endpackage

// File: rtl/gpio_sync_gate.sv
// Two-stage input synchronizer whose stages advance only while en is high.
// Assumes en is driven from registered bus decode; q holds when en is low.
module gpio_sync_gate #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Shift pin levels through both stages only when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else if (en) begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_access_ctl.sv
// Privilege and target decode for one register access.
// Assumes addresses 0 and 1 are global; all others follow the protect bit.
module gpio_access_ctl
    import gpio_shared_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              supv,
    input  logic              protect,
    output logic              allowed,
    output logic              is_pa,
    output logic              is_pb
);
    logic is_global;

    // Classify the address and decide whether the requester may access it.
    always_comb begin
        is_global = (addr == A_CFG) || (addr == A_IRQ);
        is_pa     = (addr == A_PA);
        is_pb     = (addr == A_PB);
        if (is_global) allowed = supv;
        else           allowed = supv || !protect;
    end
endmodule

// File: rtl/gpio_pa_pinmux.sv
// Port A pin drive and read-back selection, per bit.
// Assumes the low MUX_W bits are the ones overridden in mux mode.
module gpio_pa_pinmux #(
    parameter int W     = 8,
    parameter int MUX_W = 3
) (
    input  logic [W-1:0]     dir,
    input  logic [W-1:0]     lat,
    input  logic             mux_on,
    input  logic [MUX_W-1:0] maddr,
    input  logic [W-1:0]     sync,
    output logic [W-1:0]     oe,
    output logic [W-1:0]     dout,
    output logic [W-1:0]     rd_val
);
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            if (gi < MUX_W) begin : g_mux
                // Low bits: multiplexer address wins over direction in mux mode.
                always_comb begin
                    oe[gi]     = mux_on ? 1'b1 : dir[gi];
                    dout[gi]   = mux_on ? maddr[gi] : lat[gi];
                    rd_val[gi] = mux_on ? maddr[gi] : (dir[gi] ? lat[gi] : sync[gi]);
                end
            end else begin : g_plain
                // High bits: plain direction-controlled pin.
                always_comb begin
                    oe[gi]     = dir[gi];
                    dout[gi]   = lat[gi];
                    rd_val[gi] = dir[gi] ? lat[gi] : sync[gi];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_shared_port.sv
// Top of the dual GPIO port: bus FSM, registers, synchronizers, pin mux.
// Assumes the master holds its request until ack/terr and drops it then.
module gpio_shared_port
    import gpio_shared_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int MUX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    input  logic              bus_supv,
    output logic [PORT_W-1:0] bus_rdata,
    output logic              bus_ack,
    output logic              bus_terr,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    output logic [PORT_W-1:0] pa_oe,
    input  logic [PORT_W-1:0] pb_in,
    input  logic [MUX_W-1:0]  mux_addr
);
    bus_st_e           st_q;
    rd_src_e           src_q;
    logic              err_q;
    logic [ADDR_W-1:0] addr_q;
    logic [PORT_W-1:0] hold_q;
    logic              protect_q;
    logic [PORT_W-1:0] irq_q;
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] lat_q;
    logic              mux_q;
    logic [MUX_W-1:0]  ma_q;

    logic              allowed, is_pa, is_pb, start;
    logic              en_a, en_b;
    logic [PORT_W-1:0] sync_a, sync_b, pa_rd, reg_rd;

    gpio_access_ctl u_acc (
        .addr    (bus_addr),
        .supv    (bus_supv),
        .protect (protect_q),
        .allowed (allowed),
        .is_pa   (is_pa),
        .is_pb   (is_pb)
    );

    // A new access is sampled only while idle.
    assign start = (st_q == ST_IDLE) && bus_req;

    // Clock a port's synchronizer only during an access to that port.
    always_comb begin
        en_a = (start && allowed && is_pa) || ((st_q == ST_WAIT) && (addr_q == A_PA));
        en_b = (start && allowed && is_pb) || ((st_q == ST_WAIT) && (addr_q == A_PB));
    end

    gpio_sync_gate #(.W(PORT_W)) u_sync_a (
        .clk (clk), .rst_n (rst_n), .en (en_a), .d (pa_in), .q (sync_a)
    );

    gpio_sync_gate #(.W(PORT_W)) u_sync_b (
        .clk (clk), .rst_n (rst_n), .en (en_b), .d (pb_in), .q (sync_b)
    );

    gpio_pa_pinmux #(.W(PORT_W), .MUX_W(MUX_W)) u_pinmux (
        .dir    (dir_q),
        .lat    (lat_q),
        .mux_on (mux_q),
        .maddr  (ma_q),
        .sync   (sync_a),
        .oe     (pa_oe),
        .dout   (pa_out),
        .rd_val (pa_rd)
    );

    // Read value for the non-port registers.
    always_comb begin
        reg_rd = '0;
        case (bus_addr)
            A_CFG:   reg_rd[0] = protect_q;
            A_IRQ:   reg_rd    = irq_q;
            A_DIR:   reg_rd    = dir_q;
            A_CTRL:  reg_rd[0] = mux_q;
            default: reg_rd    = '0;
        endcase
    end

    // Register the external multiplexer address every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) ma_q <= '0;
        else        ma_q <= mux_addr;
    end

    // Bus FSM: decode, privilege, register writes and response timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            src_q     <= RD_HOLD;
            err_q     <= 1'b0;
            addr_q    <= '0;
            hold_q    <= '0;
            protect_q <= 1'b1;
            irq_q     <= '0;
            dir_q     <= '0;
            lat_q     <= '0;
            mux_q     <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: if (bus_req) begin
                    addr_q <= bus_addr;
                    src_q  <= RD_HOLD;
                    if (!allowed) begin
                        err_q <= 1'b1;
                        st_q  <= ST_RESP;
                    end else begin
                        err_q <= 1'b0;
                        if (!bus_wr && (is_pa || is_pb)) begin
                            src_q <= is_pa ? RD_PA : RD_PB;
                            st_q  <= ST_WAIT;
                        end else begin
                            st_q <= ST_RESP;
                            if (bus_wr) begin
                                case (bus_addr)
                                    A_CFG:   protect_q <= bus_wdata[0];
                                    A_IRQ:   irq_q     <= bus_wdata;
                                    A_PA:    lat_q     <= bus_wdata;
                                    A_DIR:   dir_q     <= bus_wdata;
                                    A_CTRL:  mux_q     <= bus_wdata[0];
                                    default: ;
                                endcase
                            end else begin
                                hold_q <= reg_rd;
                            end
                        end
                    end
                end
                ST_WAIT: st_q <= ST_RESP;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Response strobes and read data multiplexing.
    always_comb begin
        bus_ack  = (st_q == ST_RESP) && !err_q;
        bus_terr = (st_q == ST_RESP) && err_q;
        if (!bus_ack)            bus_rdata = '0;
        else if (src_q == RD_PA) bus_rdata = pa_rd;
        else if (src_q == RD_PB) bus_rdata = sync_b;
        else                     bus_rdata = hold_q;
    end
endmodule

// File: rtl/gpio_shared_port_chk.sv
// Property checker for gpio_shared_port, attached with bind.
// Assumes it observes internal state by name through the bind connection.
module gpio_shared_port_chk #(
    parameter int PORT_W = 8,
    parameter int MUX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              allowed,
    input logic              is_pa,
    input logic              is_pb,
    input logic              bus_wr,
    input logic              bus_supv,
    input logic [3:0]        bus_addr,
    input logic              bus_ack,
    input logic              bus_terr,
    input logic [PORT_W-1:0] pa_oe,
    input logic [PORT_W-1:0] pa_out,
    input logic [PORT_W-1:0] dir_q,
    input logic              mux_q,
    input logic [MUX_W-1:0]  ma_q,
    input logic              en_a,
    input logic              en_b,
    input logic [PORT_W-1:0] sync_a,
    input logic [PORT_W-1:0] sync_b
);
    AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ack && bus_terr)); // R12
    AST_GLOBAL_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !bus_supv && (bus_addr < 4'h2)) |=> bus_terr); // R10
    AST_PORT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && allowed && !bus_wr && (is_pa || is_pb)) |=> !bus_ack && !bus_terr); // R5
    AST_SYNC_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en_a |=> $stable(sync_a)); // R6
    AST_SYNC_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en_b |=> $stable(sync_b)); // R6
    AST_MUX_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        mux_q |-> (&pa_oe[MUX_W-1:0]) && (pa_out[MUX_W-1:0] == ma_q)); // R7
    AST_DIR_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !mux_q |-> (pa_oe == dir_q)); // R2
endmodule

bind gpio_shared_port gpio_shared_port_chk #(.PORT_W(PORT_W), .MUX_W(MUX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .allowed  (allowed),
    .is_pa    (is_pa),
    .is_pb    (is_pb),
    .bus_wr   (bus_wr),
    .bus_supv (bus_supv),
    .bus_addr (bus_addr),
    .bus_ack  (bus_ack),
    .bus_terr (bus_terr),
    .pa_oe    (pa_oe),
    .pa_out   (pa_out),
    .dir_q    (dir_q),
    .mux_q    (mux_q),
    .ma_q     (ma_q),
    .en_a     (en_a),
    .en_b     (en_b),
    .sync_a   (sync_a),
    .sync_b   (sync_b)
);

// File: tb/gpio_shared_port_tb.sv
module gpio_shared_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0, wr = 1'b0, supv = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0, rdata, pa_out, pa_oe;
    logic [7:0] pa_in = '0, pb_in = '0;
    logic [2:0] maddr = '0;
    logic       ack, terr;
    int         n_run = 0, n_fail = 0, cyc = 0;
    bit         done = 0;

    // Model of the programmable state.
    logic [7:0] m_dir = '0, m_lat = '0, m_irq = '0;
    logic       m_mux = 0, m_prot = 1;

    always #4 clk = ~clk;

    gpio_shared_port u_dut (
        .clk (clk), .rst_n (rst_n), .bus_req (req), .bus_wr (wr),
        .bus_addr (addr), .bus_wdata (wdata), .bus_supv (supv),
        .bus_rdata (rdata), .bus_ack (ack), .bus_terr (terr),
        .pa_in (pa_in), .pa_out (pa_out), .pa_oe (pa_oe),
        .pb_in (pb_in), .mux_addr (maddr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_pa();
        logic [7:0] v;
        for (int i = 0; i < 8; i++)
            v[i] = (m_mux && i < 3) ? maddr[i] : (m_dir[i] ? m_lat[i] : pa_in[i]);
        return v;
    endfunction

    function automatic logic [7:0] exp_oe();
        return m_mux ? (m_dir | 8'h07) : m_dir;
    endfunction

    function automatic logic [7:0] exp_out();
        return m_mux ? {m_lat[7:3], maddr} : m_lat;
    endfunction

    function automatic logic ok(input logic [3:0] a, input logic sv);
        return sv || (a > 4'h1 && !m_prot);
    endfunction

    task automatic acc(input logic w, input logic [3:0] a, input logic [7:0] d,
                       input logic sv, output logic [7:0] rd, output logic er, output int lat);
        @(negedge clk);
        req = 1; wr = w; addr = a; wdata = d; supv = sv; lat = 0;
        do begin @(negedge clk); lat++; end while (!ack && !terr && lat < 8);
        rd = rdata; er = terr;
        req = 0; wr = 0;
    endtask

    // One access with model update and checks of error, latency and data.
    task automatic op(input logic w, input logic [3:0] a, input logic [7:0] d, input logic sv);
        logic [7:0] rd; logic er; int lat; logic allow; logic [7:0] e;
        allow = ok(a, sv);
        acc(w, a, d, sv, rd, er, lat);
        chk(a < 2 ? "R10 terr" : "R11 terr", er, !allow);
        if (allow) begin
            chk("R5 latency", lat, (!w && (a == 4'h2 || a == 4'h3)) ? 2 : 1);
            if (w) begin
                case (a)
                    4'h0: m_prot = d[0];
                    4'h1: m_irq  = d;
                    4'h2: m_lat  = d;
                    4'h4: m_dir  = d;
                    4'h5: m_mux  = d[0];
                    default: ;
                endcase
            end else begin
                case (a)
                    4'h0: e = {7'd0, m_prot};
                    4'h1: e = m_irq;
                    4'h2: e = exp_pa();
                    4'h3: e = pb_in;
                    4'h4: e = m_dir;
                    4'h5: e = {7'd0, m_mux};
                    default: e = 8'h00;
                endcase
                chk(a == 4'h2 ? "R3/R8 read PA" : a == 4'h3 ? "R4 read PB" : "R11 read reg", rd, e);
            end
        end
        @(negedge clk);
        chk("R2/R7 pa_oe", pa_oe, exp_oe());
        chk("R2/R7 pa_out", pa_out, exp_out());
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pa_oe", pa_oe, 8'h00);
        chk("R1 pa_out", pa_out, 8'h00);
        op(0, 4'h0, 0, 1);
        op(0, 4'h4, 0, 1);
        op(0, 4'h5, 0, 1);
        op(0, 4'h1, 0, 1);
        // R10 user access to globals refused and not performed
        op(1, 4'h1, 8'hA5, 0);
        op(1, 4'h0, 8'h00, 0);
        op(0, 4'h1, 0, 1);
        op(0, 4'h0, 0, 1);
        // R11 protect set: user refused; cleared: user accepted
        op(1, 4'h4, 8'hFF, 0);
        op(0, 4'h4, 0, 1);
        op(1, 4'h0, 8'h00, 1);
        op(1, 4'h4, 8'h0F, 0);
        op(0, 4'h4, 0, 0);
        op(0, 4'hC, 0, 0);
        // R2/R3 mixed directions
        op(1, 4'h2, 8'h5A, 1);
        pa_in = 8'hC3;
        op(0, 4'h2, 0, 1);
        // R4 port B write ignored
        pb_in = 8'h96;
        op(1, 4'h3, 8'h00, 1);
        op(0, 4'h3, 0, 1);
        // R7/R8/R9 mux override with conflicting direction
        op(1, 4'h4, 8'hF8, 1);
        maddr = 3'b101;
        op(1, 4'h5, 8'h01, 1);
        op(0, 4'h2, 0, 1);
        op(0, 4'h4, 0, 1);
        op(1, 4'h5, 8'h00, 1);
        // Random mix
        for (int k = 0; k < 300; k++) begin
            logic [3:0] a; logic w; logic sv; int sel;
            pa_in = 8'($urandom); pb_in = 8'($urandom); maddr = 3'($urandom);
            sel = $urandom % 8;
            sv  = ($urandom % 4) != 0;
            case (sel)
                0: begin a = 4'h4; w = 1; end
                1: begin a = 4'h2; w = 1; end
                2, 3: begin a = 4'h2; w = 0; end
                4: begin a = 4'h3; w = 0; end
                5: begin a = 4'h5; w = 1; end
                6: begin a = 4'h0; w = 1; end
                default: begin a = 4'($urandom); w = 1'($urandom); end
            endcase
            op(w, a, 8'($urandom), sv);
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule